// File: doc/BRIEF.md
# SPI Flash Command Protection Controller

This block is the command front end of a serial flash slave. It oversamples an SPI bus (chip select, serial clock, serial data in and out) in clock mode 0 or mode 3 on its own system clock. It decodes the one-byte opcode that opens each frame and collects the address and data bytes that follow. When chip select returns high it decides whether the instruction is allowed to run. It keeps the status register that a host polls, and it enforces write protection: a write enable latch, a two-bit protected-region field, a status lock bit qualified by a write-protect pin, and a deep power-down state that ignores nearly everything.

Accepted program and erase instructions leave as a single-cycle request with an operation code and an aligned address on an array-side port. The array answers with a completion pulse. While a page program frame is being received, its data bytes stream out on a separate write strobe with a page column, so a page buffer on the array side can capture them. The array itself and its timing are not part of this block.

Top module: `spi_flash_guard`

## Requirements
- R1: Serial data in is sampled on rising SCLK and serial data out changes on falling SCLK, MSB first, for both idle-low (mode 0) and idle-high (mode 3) clocks. After a read-status opcode (0x05), the status byte is sent and repeated on every further byte while chip select stays low, each copy taken fresh at its byte boundary.
- R2: An instruction runs only when chip select rises after a whole number of bytes (SCLK rising count a multiple of eight); otherwise the frame is discarded with no state change and no request.
- R3: Write enable (0x06) sets the write enable latch and write disable (0x04) clears it. Write status, page program, sector erase, block erase and chip erase are rejected while the latch is clear, and page data bytes are then not forwarded.
- R4: The latch clears when a write status instruction is accepted and when the array signals completion of an accepted program or erase. A rejected instruction leaves it unchanged.
- R5: The protect field selects the read-only region of the address space: 00 none, 01 the top quarter, 10 the top half, 11 everything. A program or erase whose address lies in the region is rejected. Chip erase (0xC7) is rejected whenever the field is not 00.
- R6: Write status (0x01, one data byte) is rejected while the lock bit is set and the write-protect pin is low; the protect field and lock bit keep their values.
- R7: Deep power-down (0xB9) makes the block ignore every instruction except 0xAB, and read status returns zeros. A whole 0xAB frame wakes the block; after the 0xAB opcode, the signature byte (parameter, default 0x11) is sent on every byte.
- R8: An accepted instruction raises arr_req for exactly one cycle. Page program (0x02, three address bytes and at least one data byte) uses operation 0 and a 256-byte-aligned address. Sector erase (0x20) uses operation 1 and a 4 KiB-aligned address. Block erase (0xD8) uses operation 2 and a 64 KiB-aligned address. Chip erase uses operation 3. Each data byte of an allowed page program gives one pg_wen pulse, with the column starting at the low address byte and incrementing with wrap.
- R9: After reset the latch, busy flag, protect field, lock bit and power-down state are clear, and miso, arr_req and pg_wen are low.
- R10: The busy flag is set from an accepted request until arr_done. While busy, every instruction except read status is ignored. A frame ending in the same cycle as arr_done is still judged as busy.
- R11: The status byte is {lock, 0, 0, 0, protect[1], protect[0], latch, busy} from bit 7 down to bit 0. Write status takes only data bits 7, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_req | output | 1 | One-cycle program or erase request |
| arr_op | output | 2 | Request kind: 0 program, 1 sector, 2 block, 3 chip |
| arr_addr | output | ADDR_W | Aligned target address |
| arr_done | input | 1 | Completion pulse from the array |
| pg_wen | output | 1 | Page data byte strobe |
| pg_col | output | PAGE_W | Column of the page data byte |
| pg_data | output | 8 | Page data byte |

## Verification
The delicate coincidence is the array's completion pulse landing in the same clock cycle that the end of a chip-select frame is acted on: one path clears busy and the latch, while the other judges an instruction against the busy flag. The bench raises chip select after a write enable, counts the two synchronizer stages, and places arr_done exactly on the cycle the frame end is executed. It then reads status and expects both busy and the latch clear, which shows the write enable was judged as busy and ignored. A later write enable must then set the latch.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } arr_op_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_SECT  = 8'h20;
  localparam logic [7:0] CMD_BLK   = 8'hD8;
  localparam logic [7:0] CMD_CHIP  = 8'hC7;
  localparam logic [7:0] CMD_SLEEP = 8'hB9;
  localparam logic [7:0] CMD_WAKE  = 8'hAB;
endpackage

// File: rtl/spf_spi_rx.sv
module spf_spi_rx #(
  parameter int SYNC = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             mosi,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [CNT_W-1:0] byte_no,
  output logic             frame_end,
  output logic             frame_full,
  output logic [CNT_W-1:0] frame_bytes,
  output logic             sck_fall,
  output logic             cs_idle
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [SYNC:0]   cs_p;
  logic [SYNC:0]   sck_p;
  logic [SYNC-1:0] mosi_p;
  logic [2:0]      bit_cnt;
  logic [6:0]      rx_sh;
  logic [CNT_W-1:0] nbytes;
  logic cs_s, cs_d, sck_rise;

  assign cs_s     = cs_p[SYNC-1];
  assign cs_d     = cs_p[SYNC];
  assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC] & ~cs_s;
  assign sck_fall = ~sck_p[SYNC-1] & sck_p[SYNC] & ~cs_s;
  assign frame_end   = cs_s & ~cs_d;
  assign frame_full  = (bit_cnt == 3'd0);
  assign frame_bytes = nbytes;
  assign cs_idle     = cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mosi_p <= '0;
    end else begin
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      sck_p  <= {sck_p[SYNC-1:0], sclk};
      mosi_p <= {mosi_p[SYNC-2:0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      nbytes    <= '0;
      rx_sh     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      byte_no   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (cs_d) begin
        bit_cnt <= '0;
        nbytes  <= '0;
      end else if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_p[SYNC-1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh, mosi_p[SYNC-1]};
          byte_no   <= nbytes;
          if (nbytes != SAT) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end

  // a byte takes eight SCLK rises, so its strobe never repeats next cycle
  AST_BYTE_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R1
endmodule

// File: rtl/spf_region_guard.sv
module spf_region_guard #(
  parameter int ADDR_W = 18
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  always_comb begin
    unique case (bp)
      2'b00: hit = 1'b0;
      2'b01: hit = &addr[ADDR_W-1 -: 2];
      2'b10: hit = addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_flash_guard.sv
module spi_flash_guard
  import spf_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 12,
  parameter int BLK_W  = 16,
  parameter logic [7:0] SIG = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic              wp_n,
  output logic              arr_req,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_done,
  output logic              pg_wen,
  output logic [PAGE_W-1:0] pg_col,
  output logic [7:0]        pg_data
);
  localparam int CNT_W = 3;
  localparam int AB_W  = 24;

  logic              byte_done, frame_end, frame_full, sck_fall, cs_idle;
  logic [7:0]        rx_byte;
  logic [CNT_W-1:0]  byte_no, frame_bytes;
  logic [7:0]        opc_q, wrsr_q, tx_sh;
  logic [AB_W-1:0]   addr_q;
  logic [AB_W-1:0]   addr_nx;
  logic [PAGE_W-1:0] col_q;
  logic              wel_q, busy_q, dpd_q, srwd_q;
  logic [1:0]        bp_q;
  logic              prot_hit, hw_lock, go, wake, pp_ok;
  logic [7:0]        status, resp;
  logic [ADDR_W-1:0] tgt;

  spf_spi_rx #(.SYNC(2), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .byte_done(byte_done), .rx_byte(rx_byte), .byte_no(byte_no),
    .frame_end(frame_end), .frame_full(frame_full),
    .frame_bytes(frame_bytes), .sck_fall(sck_fall), .cs_idle(cs_idle)
  );

  assign tgt = addr_q[ADDR_W-1:0];

  spf_region_guard #(.ADDR_W(ADDR_W)) u_guard (
    .bp(bp_q), .addr(tgt), .hit(prot_hit)
  );

  assign addr_nx = {addr_q[AB_W-9:0], rx_byte};
  assign status  = {srwd_q, 3'b000, bp_q, wel_q, busy_q};
  assign hw_lock = srwd_q & ~wp_n;
  assign go      = frame_end & frame_full & (frame_bytes != '0) & ~busy_q & ~dpd_q;
  assign wake    = frame_end & frame_full & (frame_bytes != '0) & ~busy_q & (opc_q == CMD_WAKE);
  assign pp_ok   = (opc_q == CMD_PROG) & wel_q & ~busy_q & ~dpd_q & ~prot_hit;

  always_comb begin
    resp = 8'h00;
    if (frame_bytes != '0) begin
      if (opc_q == CMD_RDSR && !dpd_q) resp = status;
      else if (opc_q == CMD_WAKE)      resp = SIG;
    end
  end

  // byte capture and page data forwarding
  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q   <= '0;
      addr_q  <= '0;
      wrsr_q  <= '0;
      col_q   <= '0;
      pg_wen  <= 1'b0;
      pg_col  <= '0;
      pg_data <= '0;
    end else begin
      pg_wen <= 1'b0;
      if (byte_done) begin
        if (byte_no == 3'd0) opc_q <= rx_byte;
        if (byte_no >= 3'd1 && byte_no <= 3'd3) addr_q <= addr_nx;
        if (byte_no == 3'd1) wrsr_q <= rx_byte;
        if (byte_no == 3'd3) col_q <= addr_nx[PAGE_W-1:0];
        if (byte_no >= 3'd4 && pp_ok) begin
          pg_wen  <= 1'b1;
          pg_col  <= col_q;
          pg_data <= rx_byte;
          col_q   <= col_q + 1'b1;
        end
      end
    end
  end

  // instruction execution at frame end, status and array request
  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q    <= 1'b0;
      busy_q   <= 1'b0;
      dpd_q    <= 1'b0;
      srwd_q   <= 1'b0;
      bp_q     <= 2'b00;
      arr_req  <= 1'b0;
      arr_op   <= OP_PROG;
      arr_addr <= '0;
    end else begin
      arr_req <= 1'b0;
      if (arr_done && busy_q) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end
      if (wake) dpd_q <= 1'b0;
      if (go) begin
        unique case (opc_q)
          CMD_WREN:  wel_q <= 1'b1;
          CMD_WRDI:  wel_q <= 1'b0;
          CMD_SLEEP: dpd_q <= 1'b1;
          CMD_WRSR: if (frame_bytes >= 3'd2 && wel_q && !hw_lock) begin
            bp_q   <= wrsr_q[3:2];
            srwd_q <= wrsr_q[7];
            wel_q  <= 1'b0;
          end
          CMD_PROG: if (frame_bytes >= 3'd5 && wel_q && !prot_hit) begin
            arr_req  <= 1'b1;
            arr_op   <= OP_PROG;
            arr_addr <= {tgt[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
            busy_q   <= 1'b1;
          end
          CMD_SECT: if (frame_bytes >= 3'd4 && wel_q && !prot_hit) begin
            arr_req  <= 1'b1;
            arr_op   <= OP_SECT;
            arr_addr <= {tgt[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
            busy_q   <= 1'b1;
          end
          CMD_BLK: if (frame_bytes >= 3'd4 && wel_q && !prot_hit) begin
            arr_req  <= 1'b1;
            arr_op   <= OP_BLK;
            arr_addr <= {tgt[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
            busy_q   <= 1'b1;
          end
          CMD_CHIP: if (wel_q && bp_q == 2'b00) begin
            arr_req  <= 1'b1;
            arr_op   <= OP_CHIP;
            arr_addr <= '0;
            busy_q   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // serial output, loaded at byte boundaries on falling SCLK
  always_ff @(posedge clk) begin
    if (rst) begin
      miso  <= 1'b0;
      tx_sh <= '0;
    end else if (cs_idle) begin
      miso <= 1'b0;
    end else if (sck_fall) begin
      if (frame_full) begin
        miso  <= resp[7];
        tx_sh <= {resp[6:0], 1'b0};
      end else begin
        miso  <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> wel_q); // R3
  AST_PAGE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    pg_wen |-> wel_q); // R3
  AST_REQ_WHOLE_BYTES: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> $past(frame_full && frame_end)); // R2
  AST_REQ_UNPROTECTED: assert property (@(posedge clk) disable iff (rst)
    (arr_req && arr_op != OP_CHIP) |-> !prot_hit); // R5
  AST_CHIP_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (arr_req && arr_op == OP_CHIP) |-> (bp_q == 2'b00)); // R5
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    hw_lock |=> ($stable(bp_q) && srwd_q)); // R6
  AST_SLEEP_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    dpd_q |-> !arr_req); // R7
  AST_REQ_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> (busy_q && !$past(busy_q))); // R10
endmodule

// File: tb/spi_flash_guard_bench.sv
module spi_flash_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int ADDR_W = 18;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1, arr_done = 1'b0;
  logic miso, arr_req, pg_wen;
  logic [1:0] arr_op;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] pg_col, pg_data;
  logic mode3 = 1'b0;

  int nchk = 0, nfail = 0, cyc = 0;
  int req_cnt = 0, pg_cnt = 0;
  logic [1:0] req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0] pg_col_log [4];
  logic [7:0] pg_dat_log [4];
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_guard u_spi_flash_guard (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .wp_n(wp_n), .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_done(arr_done), .pg_wen(pg_wen), .pg_col(pg_col), .pg_data(pg_data)
  );

  always @(posedge clk) begin
    if (!rst && arr_req) begin
      req_cnt <= req_cnt + 1; req_op <= arr_op; req_addr <= arr_addr;
    end
    if (!rst && pg_wen) begin
      if (pg_cnt < 4) begin pg_col_log[pg_cnt] <= pg_col; pg_dat_log[pg_cnt] <= pg_data; end
      pg_cnt <= pg_cnt + 1;
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      nchk = nchk + 1; nfail = nfail + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sclk = 1'b0; mosi = b;
    wait_n(HALF);
    r = miso;
    sclk = 1'b1;
    wait_n(HALF);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic cs_begin();
    @(negedge clk);
    sclk = mode3;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(4);
  endtask

  task automatic cs_end();
    if (!mode3) sclk = 1'b0;
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(8);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_begin(); spi_byte(op, d); cs_end();
  endtask

  task automatic cmd4(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    cs_begin(); spi_byte(op, d);
    spi_byte(a[23:16], d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
    cs_end();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_begin(); spi_byte(8'h01, d); spi_byte(v, d); cs_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_begin(); spi_byte(8'h05, d); spi_byte(8'h00, s); cs_end();
  endtask

  task automatic pulse_done();
    @(negedge clk); arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
    wait_n(2);
  endtask

  // {send write enable first, wp_n, write-status data, expected status}
  localparam logic [17:0] VEC [8] = '{
    {1'b1, 1'b1, 8'h04, 8'h04},
    {1'b0, 1'b1, 8'h00, 8'h04},
    {1'b1, 1'b1, 8'h8C, 8'h8C},
    {1'b1, 1'b0, 8'h00, 8'h8E},
    {1'b1, 1'b1, 8'h08, 8'h08},
    {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h7F, 8'h0C},
    {1'b1, 1'b1, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] s, s2, d;
    int rc;
    wait_n(10);
    chk("R9 arr_req after reset", {31'b0, arr_req}, 32'd0);
    chk("R9 pg_wen after reset", {31'b0, pg_wen}, 32'd0);
    chk("R9 miso after reset", {31'b0, miso}, 32'd0);
    @(negedge clk); rst = 1'b0;
    wait_n(4);
    rdsr(s); chk("R9 status after reset", s, 8'h00);

    // R6 / R11 / R3: status write table
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][17]) cmd1(8'h06);
      wp_n = VEC[i][16];
      wrsr(VEC[i][15:8]);
      wp_n = 1'b1;
      rdsr(s);
      chk($sformatf("R6 R11 table entry %0d", i), s, VEC[i][7:0]);
    end

    // R1: mode 3 framing, R3: enable and disable
    mode3 = 1'b1;
    cmd1(8'h06); rdsr(s); chk("R1 mode3 status after enable", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R3 disable clears latch", s, 8'h00);
    mode3 = 1'b0;

    // R2: partial frame discarded
    cmd1(8'h06);
    rc = req_cnt;
    cs_begin(); spi_byte(8'h20, d); spi_byte(8'h01, d); spi_byte(8'h23, d); spi_byte(8'h45, d);
    for (int i = 0; i < 3; i++) spi_bit(1'b0, d[0]);
    cs_end();
    chk("R2 partial frame no request", req_cnt, rc);
    rdsr(s); chk("R2 partial frame keeps latch", s, 8'h02);

    // R8: sector erase with alignment
    cmd4(8'h20, 24'h012345);
    chk("R8 sector request count", req_cnt, rc + 1);
    chk("R8 sector op", req_op, 2'd1);
    chk("R8 sector address", req_addr, 18'h12000);
    // R1 / R10: continuous polling while busy
    cs_begin(); spi_byte(8'h05, d); spi_byte(8'h00, s); spi_byte(8'h00, s2); cs_end();
    chk("R10 busy poll first", s, 8'h03);
    chk("R1 busy poll repeat", s2, 8'h03);
    cmd1(8'h04); rdsr(s); chk("R10 disable ignored while busy", s, 8'h03);

    // R10: completion coincides with frame end of a write enable
    cs_begin(); spi_byte(8'h06, d);
    sclk = 1'b0; wait_n(HALF);
    cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
    arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
    wait_n(8);
    rdsr(s); chk("R10 R4 enable at completion edge ignored", s, 8'h00);
    cmd1(8'h06); rdsr(s); chk("R3 enable after idle", s, 8'h02);

    // R5: protected region
    wrsr(8'h04);
    cmd1(8'h06);
    rc = req_cnt;
    cmd4(8'hD8, 24'h03F000);
    chk("R5 protected block rejected", req_cnt, rc);
    rdsr(s); chk("R5 rejected keeps latch", s, 8'h06);
    cmd4(8'hD8, 24'h01FFFF);
    chk("R8 block op", req_op, 2'd2);
    chk("R8 block address", req_addr, 18'h10000);
    pulse_done();
    rdsr(s); chk("R4 completion clears latch", s, 8'h04);

    // R5: chip erase
    cmd1(8'h06);
    rc = req_cnt;
    cmd1(8'hC7);
    chk("R5 chip erase rejected when protected", req_cnt, rc);
    wrsr(8'h00);
    cmd1(8'h06); cmd1(8'hC7);
    chk("R5 chip erase accepted", req_cnt, rc + 1);
    chk("R8 chip op", req_op, 2'd3);
    pulse_done();

    // R8: page program with data stream
    cmd1(8'h06);
    cs_begin(); spi_byte(8'h02, d); spi_byte(8'h00, d); spi_byte(8'hAB, d);
    spi_byte(8'h10, d); spi_byte(8'h5A, d); spi_byte(8'hC3, d); cs_end();
    chk("R8 program op", req_op, 2'd0);
    chk("R8 program address", req_addr, 18'h0AB00);
    chk("R8 page byte count", pg_cnt, 2);
    chk("R8 page col 0", pg_col_log[0], 8'h10);
    chk("R8 page col 1", pg_col_log[1], 8'h11);
    chk("R8 page data 0", pg_dat_log[0], 8'h5A);
    chk("R8 page data 1", pg_dat_log[1], 8'hC3);
    pulse_done();
    rdsr(s); chk("R4 latch clear after program", s, 8'h00);

    // R3: program without latch forwards nothing
    rc = pg_cnt;
    cs_begin(); spi_byte(8'h02, d); spi_byte(8'h00, d); spi_byte(8'h00, d);
    spi_byte(8'h00, d); spi_byte(8'h77, d); cs_end();
    chk("R3 no page data without latch", pg_cnt, rc);

    // R7: deep power-down
    cmd1(8'hB9);
    cmd1(8'h06);
    rdsr(s); chk("R7 status reads zero in power-down", s, 8'h00);
    cs_begin(); spi_byte(8'hAB, d); spi_byte(8'h00, s); cs_end();
    chk("R7 signature byte", s, 8'h11);
    rdsr(s); chk("R7 enable ignored during power-down", s, 8'h00);
    cmd1(8'h06); rdsr(s); chk("R7 awake after release", s, 8'h02);

    report();
  end
endmodule